// File: doc/BRIEF.md
# Byte-Banked Load/Store Memory Controller

This block connects a processor load/store port to a 32-bit memory built from four byte-wide banks. Bank `b` holds every byte whose address has bits [1:0] equal to `b`, so one row of the four banks forms one 32-bit word. Byte, halfword and word accesses are accepted at any byte address. Values use little-endian order: the lowest-addressed byte of a value is its least significant byte.

When an access fits inside one row, it completes in a single cycle. When an access crosses into the next row, the controller splits it into two row cycles. On a load, it keeps the bytes taken from the lower row and merges them with the bytes read from the upper row. On a store, it writes each part to its own row through per-bank write enables. On the processor side, the data bus is justified: sub-word data always sits in the low lanes of `wdata` and `rdata`, and the controller moves each byte to or from its bank lane.

The bank storage is an internal array of 2^ROW_AW rows. Address bits above the row field are not decoded. The row after the last row is row 0.

Top module: `banked_mem_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `rdata` is 0.
- R2: Size codes are 00 for a byte, 01 for a halfword, and 10 or 11 for a word. An aligned word access (addr[1:0]=00) completes in one cycle and `ready` stays 1. Stored byte `wdata[8k+7:8k]` goes to address addr+k, and a load returns the byte at addr+k in `rdata[8k+7:8k]`.
- R3: A word access with addr[1:0] not equal to 00 holds `ready` low for exactly one cycle. It loads or stores the four bytes at addr to addr+3 in little-endian order across two rows.
- R4: A byte access at any offset completes in one cycle. It stores `wdata[7:0]` to the addressed bank, and a load returns that byte in `rdata[7:0]`.
- R5: A halfword at offset 0, 1 or 2 completes in one cycle. A halfword at offset 3 crosses the row boundary and holds `ready` low for one cycle. In both cases the data is the bytes at addr and addr+1 in `rdata[15:0]` or `wdata[15:0]`.
- R6: A sub-word load is zero-extended to 32 bits when `sign_ext` is 0. When `sign_ext` is 1, bit 7 of a byte load or bit 15 of a halfword load fills the upper bits.
- R7: A store changes only the bytes it addresses. Neighbouring bytes in the same row and in the next row keep their values.
- R8: While `ready` is low, `req` and every other request input are ignored. A store presented in that cycle leaves memory unchanged.
- R9: Once a split access ends, `ready` is 1 again. A request presented in that cycle is accepted without an idle cycle.
- R10: `rdata` changes only when a load completes. Stores and idle cycles leave it unchanged.
- R11: Address bits above bit ROW_AW+1 are ignored. An access that runs past the last row continues in row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, taken on a rising edge while `ready` is 1 |
| we | input | 1 | 1 for a store, 0 for a load |
| size | input | 2 | 00 byte, 01 halfword, 1x word |
| sign_ext | input | 1 | Sign-extend sub-word loads |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store data, justified to the low lanes |
| ready | output | 1 | Controller can take a request |
| rdata | output | 32 | Load result, valid after the completing edge |

## Verification
The RTL assertions check the following on every cycle:
- the stall pattern for each size and offset: one cycle for aligned words and in-row halfwords, and exactly one stall cycle for row-crossing words and halfwords;
- that a byte store enables exactly one bank;
- that `rdata` holds across stores and idle cycles.

Only the bench scenarios can show that the data is correct. These scenarios compare bytes merged across rows, lane placement, sign and zero extension, row wrap and address aliasing against a byte-array model. They also confirm that a store attempted during a stall leaves memory untouched, and that neighbouring bytes survive partial stores.

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl #(
  parameter int ROW_AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [1:0]  size,
  input  logic        sign_ext,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ready,
  output logic [31:0] rdata
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int LANES = 4;
  localparam int AW    = ROW_AW + 2;

  logic [7:0] mem [ROWS][LANES];

  logic          busy;
  logic [AW-1:0] s_addr;
  logic [31:0]   s_wdata;
  logic [1:0]    s_size;
  logic          s_we, s_sign;
  logic [31:0]   hold;

  logic [AW-1:0]     c_addr;
  logic [31:0]       c_wdata;
  logic [1:0]        c_size;
  logic              c_we, c_sign;
  logic [1:0]        off;
  logic [2:0]        nbytes;
  logic              split;
  logic              fire;
  logic [ROW_AW-1:0] cur_row;
  logic [31:0]       row_now, lower;
  logic [7:0]        lb [LANES];
  logic [31:0]       load_val;
  logic [LANES-1:0]  bank_we;
  logic [7:0]        bank_wd [LANES];
  logic              unused_hi;

  assign unused_hi = ^addr[31:AW];

  assign ready   = ~busy;
  assign fire    = busy | req;
  assign c_addr  = busy ? s_addr  : addr[AW-1:0];
  assign c_wdata = busy ? s_wdata : wdata;
  assign c_size  = busy ? s_size  : size;
  assign c_we    = busy ? s_we    : we;
  assign c_sign  = busy ? s_sign  : sign_ext;

  assign off     = c_addr[1:0];
  assign nbytes  = (c_size == 2'b00) ? 3'd1 : (c_size == 2'b01) ? 3'd2 : 3'd4;
  assign split   = ({1'b0, off} + nbytes) > 3'd4;
  assign cur_row = busy ? c_addr[AW-1:2] + 1'b1 : c_addr[AW-1:2];

  always_comb begin
    for (int b = 0; b < LANES; b++) row_now[8*b +: 8] = mem[cur_row][b];
  end

  assign lower = busy ? hold : row_now;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [2:0] idx;
      idx   = {1'b0, off} + 3'(i);
      lb[i] = idx[2] ? row_now[{idx[1:0], 3'b000} +: 8] : lower[{idx[1:0], 3'b000} +: 8];
    end
  end

  always_comb begin
    case (c_size)
      2'b00:   load_val = {{24{c_sign & lb[0][7]}}, lb[0]};
      2'b01:   load_val = {{16{c_sign & lb[1][7]}}, lb[1], lb[0]};
      default: load_val = {lb[3], lb[2], lb[1], lb[0]};
    endcase
  end

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      logic [1:0] lane;
      logic       upper_part;
      lane       = 2'(b) - off;
      upper_part = 2'(b) < off;
      bank_wd[b] = c_wdata[{lane, 3'b000} +: 8];
      bank_we[b] = fire & c_we & ({1'b0, lane} < nbytes) & (busy ? upper_part : ~upper_part);
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++)
      if (bank_we[b]) mem[cur_row][b] <= bank_wd[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rdata   <= '0;
      hold    <= '0;
      s_addr  <= '0;
      s_wdata <= '0;
      s_size  <= '0;
      s_we    <= 1'b0;
      s_sign  <= 1'b0;
    end else begin
      if (busy) busy <= 1'b0;
      else if (req && split) begin
        busy    <= 1'b1;
        hold    <= row_now;
        s_addr  <= addr[AW-1:0];
        s_wdata <= wdata;
        s_size  <= size;
        s_we    <= we;
        s_sign  <= sign_ext;
      end
      if (fire && !c_we && (busy || !split)) rdata <= load_val;
    end
  end

  a_r3_split_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r2_aligned_word_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && size[1] && addr[1:0] == 2'b00) |=> ready);
  a_r3_misaligned_word_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && size[1] && addr[1:0] != 2'b00) |=> !ready);
  a_r5_half_cross_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && size == 2'b01 && addr[1:0] == 2'b11) |=> !ready);
  a_r5_half_in_row_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && size == 2'b01 && addr[1:0] != 2'b11) |=> ready);
  a_r4_byte_store_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && we && size == 2'b00) |-> $countones(bank_we) == 1);
  a_r10_rdata_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !req) |=> $stable(rdata));
  a_r10_rdata_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && we) |=> $stable(rdata));
endmodule

// File: tb/tb_banked_mem_ctrl.sv
module tb_banked_mem_ctrl;
  localparam int CLK_P  = 10;
  localparam int ROW_AW = 6;
  localparam int NBYTE  = 4 << ROW_AW;
  localparam int WD     = 50000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0, sign_ext = 1'b0;
  logic [1:0] size = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic ready;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  logic [7:0] mdl [NBYTE];
  logic [31:0] last_load = '0;

  banked_mem_ctrl #(.ROW_AW(ROW_AW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .sign_ext(sign_ext),
    .addr(addr), .wdata(wdata), .ready(ready), .rdata(rdata));

  always #(CLK_P/2) clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic int bidx(input logic [31:0] a, input int i);
    logic [31:0] s;
    s = a + 32'(i);
    return int'(s[ROW_AW+1:0]);
  endfunction

  function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic sg, input logic [31:0] a);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < nb(sz); i++) v[8*i +: 8] = mdl[bidx(a, i)];
    if (sz == 2'b00 && sg && v[7])  v = v | 32'hFFFF_FF00;
    if (sz == 2'b01 && sg && v[15]) v = v | 32'hFFFF_0000;
    return v;
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input logic sg, input logic [31:0] a);
    if (sz != 2'b00 && sz != 2'b01) return (a[1:0] == 2'b00) ? "R2" : "R3";
    if (sg) return "R6";
    return (sz == 2'b00) ? "R4" : "R5";
  endfunction

  // One access starting just after a falling edge; leaves req low, no time spent after.
  task automatic access(input logic w, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] d);
    logic [31:0] expv;
    bit split_e;
    string tg;
    split_e = (int'(a[1:0]) + nb(sz)) > 4;
    tg = tag_of(sz, sg, a);
    expv = exp_load(sz, sg, a);
    chk("R9", {31'b0, ready}, 32'd1);
    req = 1'b1; we = w; size = sz; sign_ext = sg; addr = a; wdata = d;
    @(negedge clk);
    if (split_e) begin
      chk((sz == 2'b01) ? "R5" : "R3", {31'b0, ready}, 32'd0);
      // R8: a store presented while stalled must be ignored
      req = 1'b1; we = 1'b1; size = 2'b10; sign_ext = 1'b0;
      addr = 32'h0000_0014; wdata = 32'hDEAD_BEEF;
      @(negedge clk);
    end else begin
      chk(tg, {31'b0, ready}, 32'd1);
    end
    if (w) begin
      for (int i = 0; i < nb(sz); i++) mdl[bidx(a, i)] = d[8*i +: 8];
      chk("R10", rdata, last_load);
    end else begin
      chk(tg, rdata, expv);
      last_load = expv;
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'd20050912));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'b0, ready}, 32'd1);
    chk("R1", rdata, 32'd0);

    for (int r = 0; r < (1 << ROW_AW); r++)
      access(1'b1, 2'b10, 1'b0, 32'(r * 4), {8'(r), ~8'(r), 8'(r) ^ 8'h5A, 8'hC3});

    // R2: aligned word and little-endian lane order
    access(1'b1, 2'b10, 1'b0, 32'h20, 32'h1122_3344);
    access(1'b0, 2'b10, 1'b0, 32'h20, 32'h0);
    access(1'b0, 2'b00, 1'b0, 32'h20, 32'h0);
    chk("R2", rdata, 32'h44);
    access(1'b0, 2'b11, 1'b0, 32'h24, 32'h0);

    // R3 / R7: misaligned word store and load, neighbours intact
    access(1'b1, 2'b10, 1'b0, 32'h31, 32'hA1B2_C3D4);
    access(1'b0, 2'b10, 1'b0, 32'h31, 32'h0);
    chk("R3", rdata, 32'hA1B2_C3D4);
    access(1'b0, 2'b10, 1'b0, 32'h30, 32'h0);
    access(1'b0, 2'b10, 1'b0, 32'h34, 32'h0);
    access(1'b0, 2'b10, 1'b0, 32'h14, 32'h0);   // R8: stalled store never landed
    chk("R8", rdata, {8'h05, ~8'h05, 8'h05 ^ 8'h5A, 8'hC3});

    // R4: byte store to every lane
    for (int k = 0; k < 4; k++) access(1'b1, 2'b00, 1'b0, 32'h40 + 32'(k), 32'hFFFF_FF10 + 32'(k));
    access(1'b0, 2'b10, 1'b0, 32'h40, 32'h0);
    chk("R4", rdata, 32'h1312_1110);
    for (int k = 0; k < 4; k++) access(1'b0, 2'b00, 1'b0, 32'h40 + 32'(k), 32'h0);

    // R5: halfwords at each offset, offset 3 crosses rows
    for (int k = 0; k < 4; k++) access(1'b1, 2'b01, 1'b0, 32'h50 + 32'(5 * k), 32'h0000_9A00 + 32'(k));
    for (int k = 0; k < 4; k++) access(1'b0, 2'b01, 1'b0, 32'h50 + 32'(5 * k), 32'h0);
    access(1'b0, 2'b01, 1'b0, 32'h5F, 32'h0);
    chk("R5", rdata, 32'h0000_9A03);

    // R6: sign and zero extension
    access(1'b1, 2'b00, 1'b0, 32'h62, 32'h0000_0080);
    access(1'b0, 2'b00, 1'b1, 32'h62, 32'h0);
    chk("R6", rdata, 32'hFFFF_FF80);
    access(1'b0, 2'b00, 1'b0, 32'h62, 32'h0);
    chk("R6", rdata, 32'h0000_0080);
    access(1'b1, 2'b01, 1'b0, 32'h67, 32'h0000_8001);
    access(1'b0, 2'b01, 1'b1, 32'h67, 32'h0);
    chk("R6", rdata, 32'hFFFF_8001);

    // R11: wrap past last row and aliasing of high address bits
    access(1'b1, 2'b10, 1'b0, 32'(NBYTE - 2), 32'hCAFE_F00D);
    access(1'b0, 2'b10, 1'b0, 32'h0, 32'h0);
    chk("R11", rdata[15:0], 16'hCAFE);
    access(1'b0, 2'b10, 1'b0, 32'hFFFF_0000 | 32'(NBYTE - 2), 32'h0);
    chk("R11", rdata, 32'hCAFE_F00D);

    // R9: aligned load straight after a split one
    access(1'b0, 2'b10, 1'b0, 32'h33, 32'h0);
    access(1'b0, 2'b10, 1'b0, 32'h44, 32'h0);

    // R10: idle cycles hold rdata
    repeat (3) @(negedge clk);
    chk("R10", rdata, last_load);

    for (int n = 0; n < 600; n++)
      access(1'(($urandom % 3) == 0), 2'($urandom), 1'($urandom), $urandom, $urandom);

    report();
  end
endmodule